// File: doc/BRIEF.md
# Spectral Test Pattern Channel with Seed Reloading

This block forms the per-input bit streams of a built-in self-test pattern source for combinational logic. Each output lane is tied at build time to zero, two or three lines of an external Walsh wave generator. A lane with two lines switches between them on a half-weight random select, so each line is chosen half of the time. A lane with three lines uses two cascaded half-weight selects, giving shares of one quarter, one quarter and one half. The chosen wave bit is then inverted whenever a quarter-weight random bit is high, which adds noise in a controlled amount. A lane with no lines passes its weighted random stream straight through. The result is captured into the pattern register and sent to the circuit under test.

The Walsh counter and the cellular-automaton register that produce the wave lines and random streams sit outside the block. The block feeds them a seed word, a one-cycle load strobe and an advance enable. Seeds arrive through a valid/ready handshake, either as a whole word in one transfer or one bit per transfer, most significant bit first. In tester mode each seed yields exactly one pattern. In hybrid mode the block runs on its own for a programmable number of cycles, then stalls and requests a new seed.

The sequencer has five states. WAIT accepts a seed. SHIFT collects the rest of a serial seed. LOAD strobes the seed into the generators. APPLY captures the single tester-mode pattern. RUN generates patterns autonomously. The transitions are:
- WAIT→LOAD on a parallel transfer.
- WAIT→SHIFT on the first serial bit.
- SHIFT→LOAD on the last serial bit.
- LOAD→APPLY when `mode_i` is 0, and LOAD→RUN when it is 1.
- APPLY→WAIT always.
- RUN→WAIT when the interval expires or `mode_i` drops to 0.

Serial seeds need `SEED_W` of at least 2.

Top module: `spc_channel`

## Requirements
- R1: After reset the state is WAIT. `pat_o` and `pat_valid_o` are 0, `seed_ready_o` is 1, and `seed_load_o`, `ser_done_o` and `gen_en_o` are 0.
- R2: A pair lane computes (`sel_hi_i`=1 ? wave line B : wave line A) XOR `noise_i`. In the default build lane 1 uses A=line 1 and B=line 2.
- R3: A trio lane selects as follows:
  - If `sel_hi_i`=1 it takes line C.
  - Otherwise it takes line B when `sel_lo_i`=1 and line A when `sel_lo_i`=0.
  - The chosen bit is then XORed with `noise_i`.
  - In the default build lane 2 uses A=3, B=5, C=6 and lane 3 uses A=0, B=7, C=4.
- R4: A direct lane (lane 0 by default) outputs its `direct_i` bit unchanged. `noise_i` has no effect on it.
- R5: A parallel transfer (`seed_valid_i` and `seed_ready_o`, with `ser_sel_i`=0) puts `seed_par_i` on `seed_o` in the next cycle, with `seed_load_o` high for exactly that one cycle.
- R6: With `ser_sel_i`=1, `SEED_W` accepted bits, MSB first, form the seed. Cycles with `seed_valid_i` low are skipped. `seed_load_o` and `ser_done_o` rise together in the cycle after the last bit, and not before.
- R7: In tester mode (`mode_i`=0) each load yields `pat_valid_o` for exactly one cycle, two cycles after the load cycle. `gen_en_o` stays 0 and `seed_ready_o` is 1 again in that same cycle.
- R8: In hybrid mode (`mode_i`=1), after a load `gen_en_o` is high for `interval_i` cycles (0 counts as 1). Each such cycle is followed by a `pat_valid_o` cycle. The block then stalls with `reseed_req_o` high and `gen_en_o` low until the next seed.
- R9: A change of `mode_i` clears the interval counter. A drop to tester mode during RUN returns to WAIT without capturing.
- R10: `seed_ready_o` is high only in WAIT and SHIFT, and is therefore low whenever `seed_load_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 tester mode, 1 hybrid mode |
| ser_sel_i | input | 1 | 1 selects serial seed transfer |
| seed_valid_i | input | 1 | Seed word or bit is offered |
| seed_par_i | input | SEED_W | Parallel seed word |
| seed_bit_i | input | 1 | Serial seed bit |
| interval_i | input | CNT_W | Hybrid run length in cycles |
| wal_i | input | WAL_W | Walsh wave lines |
| sel_hi_i | input | N_LANE | Half-weight selects, first stage |
| sel_lo_i | input | N_LANE | Half-weight selects, second stage |
| noise_i | input | N_LANE | Quarter-weight noise bits |
| direct_i | input | N_LANE | Weighted streams for direct lanes |
| seed_ready_o | output | 1 | Seed transfer can be taken |
| seed_load_o | output | 1 | Load strobe to the generators |
| seed_o | output | SEED_W | Seed word to the generators |
| ser_done_o | output | 1 | Serial seed complete pulse |
| gen_en_o | output | 1 | Advance enable to the generators |
| reseed_req_o | output | 1 | Hybrid mode waiting for a seed |
| pat_o | output | N_LANE | Test pattern to the circuit under test |
| pat_valid_o | output | 1 | Pattern register holds a new pattern |

## Verification
The case that is hardest to reach from the ports is every mixing lane meeting every combination of wave lines, selects and noise. In tester mode each pattern costs a full seed transfer. The bench therefore loads one hybrid seed with a long interval and drives a fresh input combination on every cycle of the autonomous run. This sweeps all 256 wave values while hashed select, noise and direct bits vary, and each capture is compared one cycle later against arithmetic expectations. Mode drops in mid-run, gaps in a serial transfer, and a short second run after a mode change are reached by steering the handshake cycle by cycle.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_SHIFT,
        ST_LOAD,
        ST_APPLY,
        ST_RUN
    } spc_state_e;

    localparam logic [1:0] LK_DIRECT = 2'd0;
    localparam logic [1:0] LK_PAIR   = 2'd1;
    localparam logic [1:0] LK_TRIO   = 2'd2;

    localparam logic MODE_TESTER = 1'b0;
    localparam logic MODE_HYBRID = 1'b1;

endpackage

// File: rtl/spc_lane.sv
`timescale 1ns/1ps
module spc_lane
    import spc_pkg::*;
#(
    parameter logic [1:0] KIND = LK_PAIR
) (
    input  logic [2:0] comp_i,
    input  logic       sel_hi_i,
    input  logic       sel_lo_i,
    input  logic       noise_i,
    input  logic       direct_i,
    output logic       bit_o
);

    logic pair_bit;
    logic trio_bit;

    always_comb begin
        pair_bit = sel_hi_i ? comp_i[1] : comp_i[0];
        trio_bit = sel_hi_i ? comp_i[2] : (sel_lo_i ? comp_i[1] : comp_i[0]);
        unique case (KIND)
            LK_DIRECT: bit_o = direct_i;
            LK_PAIR:   bit_o = pair_bit ^ noise_i;
            default:   bit_o = trio_bit ^ noise_i;
        endcase
    end

endmodule

// File: rtl/spc_seq.sv
`timescale 1ns/1ps
module spc_seq
    import spc_pkg::*;
#(
    parameter int SEED_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              ser_sel_i,
    input  logic              seed_valid_i,
    input  logic [SEED_W-1:0] seed_par_i,
    input  logic              seed_bit_i,
    input  logic [CNT_W-1:0]  interval_i,
    output logic              seed_ready_o,
    output logic              seed_load_o,
    output logic [SEED_W-1:0] seed_o,
    output logic              ser_done_o,
    output logic              gen_en_o,
    output logic              capture_o,
    output logic              reseed_req_o,
    output logic [CNT_W-1:0]  ivl_cnt_o
);

    localparam int BCNT_W = $clog2(SEED_W) + 1;
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(SEED_W - 1);

    spc_state_e        state_q, state_d;
    logic [BCNT_W-1:0] bcnt_q;
    logic [SEED_W-1:0] seed_q;
    logic              done_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mode_q;

    logic accept;
    logic last_bit;
    logic run_end;
    logic mode_chg;
    logic hybrid;

    assign hybrid   = (mode_i == MODE_HYBRID);
    assign accept   = seed_valid_i && seed_ready_o;
    assign last_bit = (bcnt_q == LAST_BIT);
    assign run_end  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, interval_i};
    assign mode_chg = (mode_i != mode_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (accept) state_d = ser_sel_i ? ST_SHIFT : ST_LOAD;
            ST_SHIFT: if (accept && last_bit) state_d = ST_LOAD;
            ST_LOAD:  state_d = hybrid ? ST_RUN : ST_APPLY;
            ST_APPLY: state_d = ST_WAIT;
            ST_RUN:   if (!hybrid || run_end) state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        seed_ready_o = (state_q == ST_WAIT) || (state_q == ST_SHIFT);
        seed_load_o  = (state_q == ST_LOAD);
        gen_en_o     = (state_q == ST_RUN) && hybrid;
        capture_o    = (state_q == ST_APPLY) || ((state_q == ST_RUN) && hybrid);
        reseed_req_o = seed_ready_o && hybrid;
    end

    assign seed_o     = seed_q;
    assign ser_done_o = done_q;
    assign ivl_cnt_o  = cnt_q;

    // seed assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
            bcnt_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (state_q == ST_WAIT && !ser_sel_i) begin
                    seed_q <= seed_par_i;
                    bcnt_q <= '0;
                end else if (state_q == ST_WAIT) begin
                    seed_q <= {seed_q[SEED_W-2:0], seed_bit_i};
                    bcnt_q <= BCNT_W'(1);
                end else begin
                    seed_q <= {seed_q[SEED_W-2:0], seed_bit_i};
                    if (last_bit) begin
                        bcnt_q <= '0;
                        done_q <= 1'b1;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
            end
        end
    end

    // interval counter and mode history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= MODE_TESTER;
        end else begin
            mode_q <= mode_i;
            if (mode_chg || state_q == ST_LOAD)
                cnt_q <= '0;
            else if (state_q == ST_RUN && hybrid)
                cnt_q <= run_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spc_channel.sv
`timescale 1ns/1ps
module spc_channel
    import spc_pkg::*;
#(
    parameter int WAL_W  = 8,
    parameter int N_LANE = 4,
    parameter int SEED_W = 8,
    parameter int CNT_W  = 16,
    parameter logic [2*N_LANE-1:0] LANE_KIND = {LK_TRIO, LK_TRIO, LK_PAIR, LK_DIRECT},
    parameter logic [N_LANE*3*$clog2(WAL_W)-1:0] LANE_COMP =
        {9'b100_111_000, 9'b110_101_011, 9'b000_010_001, 9'b000_000_000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              ser_sel_i,
    input  logic              seed_valid_i,
    input  logic [SEED_W-1:0] seed_par_i,
    input  logic              seed_bit_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic [WAL_W-1:0]  wal_i,
    input  logic [N_LANE-1:0] sel_hi_i,
    input  logic [N_LANE-1:0] sel_lo_i,
    input  logic [N_LANE-1:0] noise_i,
    input  logic [N_LANE-1:0] direct_i,
    output logic              seed_ready_o,
    output logic              seed_load_o,
    output logic [SEED_W-1:0] seed_o,
    output logic              ser_done_o,
    output logic              gen_en_o,
    output logic              reseed_req_o,
    output logic [N_LANE-1:0] pat_o,
    output logic              pat_valid_o
);

    localparam int IDX_W  = $clog2(WAL_W);
    localparam int STRIDE = 3 * IDX_W;

    logic              capture;
    logic [CNT_W-1:0]  ivl_cnt;
    logic [N_LANE-1:0] lane_bit;
    logic [N_LANE-1:0] pat_q;
    logic              pat_valid_q;

    spc_seq #(.SEED_W(SEED_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .ser_sel_i    (ser_sel_i),
        .seed_valid_i (seed_valid_i),
        .seed_par_i   (seed_par_i),
        .seed_bit_i   (seed_bit_i),
        .interval_i   (interval_i),
        .seed_ready_o (seed_ready_o),
        .seed_load_o  (seed_load_o),
        .seed_o       (seed_o),
        .ser_done_o   (ser_done_o),
        .gen_en_o     (gen_en_o),
        .capture_o    (capture),
        .reseed_req_o (reseed_req_o),
        .ivl_cnt_o    (ivl_cnt)
    );

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        localparam int CA = int'(LANE_COMP[l*STRIDE          +: IDX_W]);
        localparam int CB = int'(LANE_COMP[l*STRIDE + IDX_W   +: IDX_W]);
        localparam int CC = int'(LANE_COMP[l*STRIDE + 2*IDX_W +: IDX_W]);
        logic [2:0] comp;
        assign comp = {wal_i[CC], wal_i[CB], wal_i[CA]};
        spc_lane #(.KIND(LANE_KIND[2*l +: 2])) u_lane (
            .comp_i   (comp),
            .sel_hi_i (sel_hi_i[l]),
            .sel_lo_i (sel_lo_i[l]),
            .noise_i  (noise_i[l]),
            .direct_i (direct_i[l]),
            .bit_o    (lane_bit[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q       <= '0;
            pat_valid_q <= 1'b0;
        end else begin
            pat_valid_q <= capture;
            if (capture) pat_q <= lane_bit;
        end
    end

    assign pat_o       = pat_q;
    assign pat_valid_o = pat_valid_q;

endmodule

// File: rtl/spc_channel_chk.sv
`timescale 1ns/1ps
module spc_channel_chk #(
    parameter int N_LANE = 4,
    parameter int CNT_W  = 16,
    parameter logic [2*N_LANE-1:0] LANE_KIND = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              seed_ready_o,
    input logic              seed_load_o,
    input logic              ser_done_o,
    input logic              gen_en_o,
    input logic              reseed_req_o,
    input logic              pat_valid_o,
    input logic [N_LANE-1:0] pat_o,
    input logic [N_LANE-1:0] direct_i,
    input logic [CNT_W-1:0]  ivl_cnt
);

    // R5: load strobe lasts one cycle
    a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load_o |=> !seed_load_o);

    // R10: no seed accepted while loading
    a_r10_ready_vs_load: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load_o |-> !seed_ready_o);

    // R6: serial completion coincides with load
    a_r6_done_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done_o |-> seed_load_o);

    // R8: every enabled cycle yields a pattern
    a_r8_gen_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en_o |=> pat_valid_o);

    // R8: stalled while requesting a seed
    a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_req_o |-> !gen_en_o);

    // R9: mode change clears the interval counter
    a_r9_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |=> (ivl_cnt == '0));

    for (genvar l = 0; l < N_LANE; l++) begin : g_direct
        if (LANE_KIND[2*l +: 2] == 2'd0) begin : g_on
            // R4: direct lane passes its stream through
            a_r4_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
                pat_valid_o |-> (pat_o[l] == $past(direct_i[l])));
        end
    end

endmodule

bind spc_channel spc_channel_chk #(
    .N_LANE(N_LANE), .CNT_W(CNT_W), .LANE_KIND(LANE_KIND)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .seed_ready_o (seed_ready_o),
    .seed_load_o  (seed_load_o),
    .ser_done_o   (ser_done_o),
    .gen_en_o     (gen_en_o),
    .reseed_req_o (reseed_req_o),
    .pat_valid_o  (pat_valid_o),
    .pat_o        (pat_o),
    .direct_i     (direct_i),
    .ivl_cnt      (ivl_cnt)
);

// File: tb/sim_spc_channel.sv
`timescale 1ns/1ps
module sim_spc_channel;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_i, ser_sel_i, seed_valid_i, seed_bit_i;
    logic [7:0] seed_par_i;
    logic [15:0] interval_i;
    logic [7:0] wal_i;
    logic [3:0] sel_hi_i, sel_lo_i, noise_i, direct_i;
    logic       seed_ready_o, seed_load_o, ser_done_o, gen_en_o, reseed_req_o, pat_valid_o;
    logic [7:0] seed_o;
    logic [3:0] pat_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spc_channel u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pat(logic [7:0] w, logic [3:0] a, logic [3:0] b,
                                           logic [3:0] n, logic [3:0] d);
        logic [3:0] r;
        r[0] = d[0];
        r[1] = (a[1] ? w[2] : w[1]) ^ n[1];
        r[2] = (a[2] ? w[6] : (b[2] ? w[5] : w[3])) ^ n[2];
        r[3] = (a[3] ? w[4] : (b[3] ? w[7] : w[0])) ^ n[3];
        return r;
    endfunction

    logic [3:0] exp_q;

    task automatic drive_vec(input int k);
        logic [31:0] x;
        x = k * 32'h9E37_79B1;
        wal_i    = k[7:0];
        sel_hi_i = x[19:16];
        sel_lo_i = x[23:20];
        noise_i  = x[27:24];
        direct_i = x[31:28];
        exp_q = exp_pat(wal_i, sel_hi_i, sel_lo_i, noise_i, direct_i);
    endtask

    // starts at a negedge in WAIT, ends at negedge in LOAD
    task automatic par_load(input logic [7:0] s);
        ser_sel_i = 1'b0; seed_valid_i = 1'b1; seed_par_i = s;
        @(negedge clk);
        seed_valid_i = 1'b0;
        chk(seed_load_o == 1'b1, "R5 load strobe", seed_load_o, 1);
        chk(seed_o == s, "R5 seed word", seed_o, s);
        chk(seed_ready_o == 1'b0, "R10 ready low in LOAD", seed_ready_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_i = 1'b0; ser_sel_i = 1'b0; seed_valid_i = 1'b0;
        seed_bit_i = 1'b0; seed_par_i = '0; interval_i = 16'd1;
        drive_vec(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pat_o == 4'h0 && pat_valid_o == 1'b0, "R1 pattern reset", {pat_valid_o, pat_o}, 0);
        chk(seed_ready_o == 1'b1, "R1 ready after reset", seed_ready_o, 1);
        chk(!seed_load_o && !ser_done_o && !gen_en_o, "R1 strobes idle",
            {seed_load_o, ser_done_o, gen_en_o}, 0);

        // R7 tester mode, one pattern per seed (R2 R3 R4 values too)
        for (int v = 0; v < 64; v++) begin
            par_load(8'(v * 37 + 5));
            chk(pat_valid_o == 1'b0, "R7 no stale strobe", pat_valid_o, 0);
            drive_vec(v * 61 + 7);
            @(negedge clk);
            chk(pat_valid_o == 1'b0 && gen_en_o == 1'b0, "R7 apply cycle",
                {pat_valid_o, gen_en_o}, 0);
            @(negedge clk);
            chk(pat_valid_o == 1'b1, "R7 one strobe", pat_valid_o, 1);
            chk(pat_o == exp_q, "R2/R3/R4 tester pattern", pat_o, exp_q);
            chk(seed_ready_o == 1'b1 && gen_en_o == 1'b0, "R7 ready again",
                {seed_ready_o, gen_en_o}, 2);
        end

        // R6 serial seed with a gap
        begin
            logic [7:0] sv;
            sv = 8'h3C;
            ser_sel_i = 1'b1;
            for (int i = 0; i < 8; i++) begin
                seed_valid_i = 1'b1; seed_bit_i = sv[7 - i];
                @(negedge clk);
                seed_valid_i = 1'b0;
                if (i < 7) chk(seed_load_o == 1'b0, "R6 no early load", seed_load_o, 0);
                if (i == 3) begin
                    @(negedge clk);
                    chk(seed_load_o == 1'b0 && seed_ready_o == 1'b1, "R6 gap held",
                        {seed_load_o, seed_ready_o}, 1);
                end
            end
            chk(seed_load_o && ser_done_o, "R6 load with done", {seed_load_o, ser_done_o}, 3);
            chk(seed_o == sv, "R6 serial word", seed_o, sv);
            ser_sel_i = 1'b0;
            @(negedge clk);
            chk(ser_done_o == 1'b0, "R6 done single", ser_done_o, 0);
            @(negedge clk);
        end

        // R8 hybrid sweep
        mode_i = 1'b1; interval_i = 16'd4096;
        @(negedge clk);
        chk(reseed_req_o == 1'b1, "R8 request in wait", reseed_req_o, 1);
        par_load(8'h81);
        @(negedge clk);
        chk(gen_en_o == 1'b1, "R8 run enabled", gen_en_o, 1);
        for (int k = 0; k < 4096; k++) begin
            drive_vec(k);
            @(negedge clk);
            chk(pat_valid_o == 1'b1, "R8 valid each cycle", pat_valid_o, 1);
            chk(pat_o == exp_q, "R2/R3/R4 hybrid pattern", pat_o, exp_q);
            if (k < 4095) chk(gen_en_o == 1'b1, "R8 still running", gen_en_o, 1);
            else chk(!gen_en_o && reseed_req_o, "R8 stall at end", {gen_en_o, reseed_req_o}, 1);
        end
        @(negedge clk);
        chk(pat_valid_o == 1'b0 && reseed_req_o == 1'b1, "R8 stalled",
            {pat_valid_o, reseed_req_o}, 1);

        // R9 mode drop mid-run, then fresh short run
        interval_i = 16'd100;
        par_load(8'h42);
        @(negedge clk);
        drive_vec(9);
        @(negedge clk);
        chk(pat_valid_o == 1'b1, "R9 running before drop", pat_valid_o, 1);
        mode_i = 1'b0;
        @(negedge clk);
        chk(pat_valid_o == 1'b0 && gen_en_o == 1'b0, "R9 no capture after drop",
            {pat_valid_o, gen_en_o}, 0);
        chk(seed_ready_o == 1'b1 && reseed_req_o == 1'b0, "R9 back in wait",
            {seed_ready_o, reseed_req_o}, 2);
        mode_i = 1'b1; interval_i = 16'd2;
        @(negedge clk);
        par_load(8'h17);
        @(negedge clk);
        chk(gen_en_o == 1'b1, "R9 fresh run cycle 1", gen_en_o, 1);
        @(negedge clk);
        chk(gen_en_o == 1'b1, "R9 fresh run cycle 2", gen_en_o, 1);
        @(negedge clk);
        chk(gen_en_o == 1'b0 && pat_valid_o == 1'b1, "R9 run of two ends",
            {gen_en_o, pat_valid_o}, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule